// File: doc/BRIEF.md
# Write-Back Data Cache with Dead-Line Scrub Commands

This block is a small set-associative write-back data cache. It serves word loads and stores from one requester. It also accepts four per-line management commands that software issues once it knows the contents of a line are dead.

- **Drop:** discards a line outright.
- **Forget-dirty:** keeps a line but stops it from being written back.
- **Retire:** keeps a line, stops its write-back and makes it the next victim of its set.
- **Zero-fill:** creates a line of zeroes in the cache without reading memory.

Together these remove write-backs of dead data and remove the fetches that a fetch-on-write cache would otherwise perform before zero-initialising memory.

Requests arrive on a valid/ready port, and only one request is in flight at a time. A single-cycle done pulse ends each request and carries the load data. The memory side moves one whole line per transfer, for both fills and write-backs. A transfer completes in the cycle the memory raises its ready signal. Read data is taken in that same cycle.

Top module: `scrub_cache`

## Requirements
- R1: Request opcodes are 0 load, 1 store, 2 drop, 3 forget-dirty, 4 retire, 5 zero-fill. Byte addresses split into word select in bits 3:2, set index in bits 7:4 and tag in bits 15:8. A load that hits returns the addressed 32-bit word with no memory transfer.
- R2: A store that misses first reads the whole line from memory, then merges the word into it. The line becomes dirty, and the unwritten words keep their memory values.
- R3: Evicting a dirty line writes all of its bytes to memory at its own line address. Evicting a clean line causes no memory transfer.
- R4: Drop on a resident line removes it without any write-back, even when it is dirty. A later access to that address misses and refetches.
- R5: Forget-dirty on a resident line leaves it resident with its data intact but clean. Its later eviction writes nothing.
- R6: Retire on a resident line makes it clean and moves it to the least-recently-used position of its set, so the next miss in that set replaces it.
- R7: Zero-fill makes the target line resident, all zero and dirty, whether it hits or misses, and never reads memory. On a miss whose victim is dirty, the victim is written back first.
- R8: The three dead-line commands (drop, forget-dirty, retire) never cause a memory transfer. When their address misses, they complete after a single lookup cycle and change no line, dirty or recency state.
- R9: Each set keeps a true LRU order. Load hits, store hits and zero-fill make the line most-recently-used. A miss replaces the lowest-numbered invalid way, or the least-recently-used way when all ways are valid.
- R10: `req_ready` is high only while the cache is idle, and no memory transfer is active then. Request addresses are word aligned. `resp_done` lasts exactly one cycle per request.
- R11: After reset every line is invalid and clean, `req_ready` is high, and `resp_done` and `mem_valid` are low.
- R12: A dirty line is always valid, so no scrub leaves a dirty line that is not present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Cache idle and accepting a request |
| req_op | input | 3 | Request opcode |
| req_addr | input | 16 | Byte address, word aligned |
| req_wdata | input | 32 | Store data |
| resp_done | output | 1 | One-cycle completion pulse |
| resp_rdata | output | 32 | Load data, valid with resp_done |
| mem_valid | output | 1 | Memory transfer requested |
| mem_write | output | 1 | 1 write-back, 0 fill |
| mem_addr | output | 16 | Line-aligned byte address |
| mem_wdata | output | 128 | Write-back line data |
| mem_ready | input | 1 | Memory completes the transfer this cycle |
| mem_rdata | input | 128 | Fill line data, valid with mem_ready |

## Verification
The bench builds the cache with its default parameters: four ways, sixteen sets, sixteen-byte lines and sixteen-bit addresses. Four ways is enough for one set to hold a complete recency order. That makes it observable which line a retire, a hit or a miss pushes out, and whether the line leaving is written back. Sixteen sets let every scenario work in a set of its own, so earlier scenarios do not disturb later ones. Tags below sixteen keep the bench memory at 256 lines.

// File: rtl/scrub_cache_pkg.sv
package scrub_cache_pkg;

    typedef enum logic [2:0] {
        OP_LOAD    = 3'd0,
        OP_STORE   = 3'd1,
        OP_DROP    = 3'd2,
        OP_FORGET  = 3'd3,
        OP_RETIRE  = 3'd4,
        OP_ZFILL   = 3'd5
    } scrub_op_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOOKUP = 2'd1,
        ST_EVICT  = 2'd2,
        ST_FILL   = 2'd3
    } ctl_state_e;

endpackage

// File: rtl/scrub_way_match.sv
module scrub_way_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 8,
    parameter int AGE_W = 2,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]             valid_i,
    input  logic [WAYS-1:0][TAG_W-1:0]  tags_i,
    input  logic [WAYS-1:0][AGE_W-1:0]  ages_i,
    input  logic [TAG_W-1:0]            look_tag_i,
    output logic [WAYS-1:0]             hit_vec_o,
    output logic                        hit_o,
    output logic [WAY_W-1:0]            hit_way_o,
    output logic [WAY_W-1:0]            victim_o
);

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec_o[w] = valid_i[w] && (tags_i[w] == look_tag_i);
    end

    assign hit_o = |hit_vec_o;

    always_comb begin
        hit_way_o = '0;
        victim_o  = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (hit_vec_o[w]) hit_way_o = WAY_W'(w);
            if (ages_i[w] == AGE_W'(WAYS - 1)) victim_o = WAY_W'(w);
        end
        // lowest-numbered invalid way overrides the recency choice
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!valid_i[w]) victim_o = WAY_W'(w);
        end
    end

endmodule

// File: rtl/scrub_lru_rank.sv
module scrub_lru_rank #(
    parameter int WAYS   = 4,
    parameter int AGE_W  = 2,
    parameter bit DEMOTE = 1'b0,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0][AGE_W-1:0] ages_i,
    input  logic [WAY_W-1:0]           way_i,
    output logic [WAYS-1:0][AGE_W-1:0] ages_o
);

    logic [AGE_W-1:0] pivot;
    assign pivot = ages_i[way_i];

    for (genvar w = 0; w < WAYS; w++) begin : g_age
        if (DEMOTE) begin : g_down
            always_comb begin
                if (way_i == WAY_W'(w))    ages_o[w] = AGE_W'(WAYS - 1);
                else if (ages_i[w] > pivot) ages_o[w] = ages_i[w] - 1'b1;
                else                        ages_o[w] = ages_i[w];
            end
        end else begin : g_up
            always_comb begin
                if (way_i == WAY_W'(w))    ages_o[w] = '0;
                else if (ages_i[w] < pivot) ages_o[w] = ages_i[w] + 1'b1;
                else                        ages_o[w] = ages_i[w];
            end
        end
    end

endmodule

// File: rtl/scrub_cache.sv
module scrub_cache
    import scrub_cache_pkg::*;
#(
    parameter int WAYS       = 4,
    parameter int SETS       = 16,
    parameter int LINE_BYTES = 16,
    parameter int ADDR_W     = 16,
    parameter int WORD_W     = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [2:0]              req_op,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [WORD_W-1:0]       req_wdata,
    output logic                    resp_done,
    output logic [WORD_W-1:0]       resp_rdata,
    output logic                    mem_valid,
    output logic                    mem_write,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [LINE_BYTES*8-1:0] mem_wdata,
    input  logic                    mem_ready,
    input  logic [LINE_BYTES*8-1:0] mem_rdata
);

    localparam int LINE_W   = LINE_BYTES * 8;
    localparam int OFF_W    = $clog2(LINE_BYTES);
    localparam int IDX_W    = $clog2(SETS);
    localparam int BOFF_W   = $clog2(WORD_W / 8);
    localparam int WSEL_W   = OFF_W - BOFF_W;
    localparam int TAG_W    = ADDR_W - OFF_W - IDX_W;
    localparam int WADDR_W  = ADDR_W - BOFF_W;
    localparam int WAY_W    = $clog2(WAYS);
    localparam int AGE_W    = WAY_W;

    typedef struct packed {
        ctl_state_e          st;
        scrub_op_e           op;
        logic [WADDR_W-1:0]  waddr;
        logic [WORD_W-1:0]   wdata;
        logic [WAY_W-1:0]    vway;
        logic                done;
        logic [WORD_W-1:0]   rdata;
    } ctl_t;

    ctl_t c_d, c_q;
    logic [SETS-1:0][WAYS-1:0]             valid_d, valid_q, dirty_d, dirty_q;
    logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]  tag_d, tag_q;
    logic [SETS-1:0][WAYS-1:0][LINE_W-1:0] data_d, data_q;
    logic [SETS-1:0][WAYS-1:0][AGE_W-1:0]  age_d, age_q;

    logic [IDX_W-1:0]  set_idx;
    logic [TAG_W-1:0]  look_tag;
    logic [WSEL_W-1:0] wsel;
    int                bit_lo;
    logic [WAYS-1:0]   hit_vec;
    logic              hit;
    logic [WAY_W-1:0]  hit_way, victim;
    logic [WAYS-1:0][AGE_W-1:0] ages_up, ages_down;

    assign wsel     = c_q.waddr[WSEL_W-1:0];
    assign set_idx  = c_q.waddr[WSEL_W +: IDX_W];
    assign look_tag = c_q.waddr[WSEL_W + IDX_W +: TAG_W];
    assign bit_lo   = int'(wsel) * WORD_W;

    scrub_way_match #(.WAYS(WAYS), .TAG_W(TAG_W), .AGE_W(AGE_W)) u_match (
        .valid_i    (valid_q[set_idx]),
        .tags_i     (tag_q[set_idx]),
        .ages_i     (age_q[set_idx]),
        .look_tag_i (look_tag),
        .hit_vec_o  (hit_vec),
        .hit_o      (hit),
        .hit_way_o  (hit_way),
        .victim_o   (victim)
    );

    scrub_lru_rank #(.WAYS(WAYS), .AGE_W(AGE_W), .DEMOTE(1'b0)) u_lru_up (
        .ages_i (age_q[set_idx]),
        .way_i  (hit_way),
        .ages_o (ages_up)
    );

    scrub_lru_rank #(.WAYS(WAYS), .AGE_W(AGE_W), .DEMOTE(1'b1)) u_lru_down (
        .ages_i (age_q[set_idx]),
        .way_i  (hit_way),
        .ages_o (ages_down)
    );

    always_comb begin
        c_d       = c_q;
        c_d.done  = 1'b0;
        valid_d   = valid_q;
        dirty_d   = dirty_q;
        tag_d     = tag_q;
        data_d    = data_q;
        age_d     = age_q;
        req_ready = 1'b0;
        mem_valid = 1'b0;
        mem_write = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;

        unique case (c_q.st)
            ST_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    c_d.st    = ST_LOOKUP;
                    c_d.op    = scrub_op_e'(req_op);
                    c_d.waddr = req_addr[ADDR_W-1:BOFF_W];
                    c_d.wdata = req_wdata;
                end
            end
            ST_LOOKUP: begin
                c_d.st   = ST_IDLE;
                c_d.done = 1'b1;
                unique case (c_q.op)
                    OP_LOAD, OP_STORE, OP_ZFILL: begin
                        if (hit) begin
                            if (c_q.op == OP_LOAD) begin
                                c_d.rdata = data_q[set_idx][hit_way][bit_lo +: WORD_W];
                            end else if (c_q.op == OP_STORE) begin
                                data_d[set_idx][hit_way][bit_lo +: WORD_W] = c_q.wdata;
                                dirty_d[set_idx][hit_way] = 1'b1;
                            end else begin
                                data_d[set_idx][hit_way]  = '0;
                                dirty_d[set_idx][hit_way] = 1'b1;
                            end
                            age_d[set_idx] = ages_up;
                        end else begin
                            c_d.done = 1'b0;
                            c_d.vway = victim;
                            if (valid_q[set_idx][victim] && dirty_q[set_idx][victim]) begin
                                c_d.st = ST_EVICT;
                            end else if (c_q.op == OP_ZFILL) begin
                                // claim the clean victim; the next lookup hits and zeroes it
                                c_d.st = ST_LOOKUP;
                                valid_d[set_idx][victim] = 1'b1;
                                dirty_d[set_idx][victim] = 1'b0;
                                tag_d[set_idx][victim]   = look_tag;
                                data_d[set_idx][victim]  = '0;
                            end else begin
                                c_d.st = ST_FILL;
                            end
                        end
                    end
                    OP_DROP: begin
                        if (hit) begin
                            valid_d[set_idx][hit_way] = 1'b0;
                            dirty_d[set_idx][hit_way] = 1'b0;
                        end
                    end
                    OP_FORGET: begin
                        if (hit) dirty_d[set_idx][hit_way] = 1'b0;
                    end
                    OP_RETIRE: begin
                        if (hit) begin
                            dirty_d[set_idx][hit_way] = 1'b0;
                            age_d[set_idx] = ages_down;
                        end
                    end
                    default: ;
                endcase
            end
            ST_EVICT: begin
                mem_valid = 1'b1;
                mem_write = 1'b1;
                mem_addr  = {tag_q[set_idx][c_q.vway], set_idx, {OFF_W{1'b0}}};
                mem_wdata = data_q[set_idx][c_q.vway];
                if (mem_ready) begin
                    valid_d[set_idx][c_q.vway] = 1'b0;
                    dirty_d[set_idx][c_q.vway] = 1'b0;
                    c_d.st = ST_LOOKUP;
                end
            end
            ST_FILL: begin
                mem_valid = 1'b1;
                mem_addr  = {look_tag, set_idx, {OFF_W{1'b0}}};
                if (mem_ready) begin
                    valid_d[set_idx][c_q.vway] = 1'b1;
                    dirty_d[set_idx][c_q.vway] = 1'b0;
                    tag_d[set_idx][c_q.vway]   = look_tag;
                    data_d[set_idx][c_q.vway]  = mem_rdata;
                    c_d.st = ST_LOOKUP;
                end
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q     <= '0;
            valid_q <= '0;
            dirty_q <= '0;
            tag_q   <= '0;
            data_q  <= '0;
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    age_q[s][w] <= AGE_W'(w);
                end
            end
        end else begin
            c_q     <= c_d;
            valid_q <= valid_d;
            dirty_q <= dirty_d;
            tag_q   <= tag_d;
            data_q  <= data_d;
            age_q   <= age_d;
        end
    end

    assign resp_done  = c_q.done;
    assign resp_rdata = c_q.rdata;

    AST_TAG_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(hit_vec)); // R1
    AST_NO_FETCH_ZFILL: assert property (@(posedge clk) disable iff (!rst_n) (mem_valid && !mem_write) |-> (c_q.op == OP_LOAD || c_q.op == OP_STORE)); // R7
    AST_SCRUB_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n) mem_valid |-> !(c_q.op == OP_DROP || c_q.op == OP_FORGET || c_q.op == OP_RETIRE)); // R8
    AST_WB_ONLY_DIRTY: assert property (@(posedge clk) disable iff (!rst_n) (mem_valid && mem_write) |-> (valid_q[set_idx][c_q.vway] && dirty_q[set_idx][c_q.vway])); // R3
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) resp_done |=> !resp_done); // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) req_ready |-> !mem_valid); // R10
    AST_WORD_ALIGN: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && req_ready) |-> (req_addr[BOFF_W-1:0] == '0)); // R10

    for (genvar s = 0; s < SETS; s++) begin : g_chk_set
        for (genvar w = 0; w < WAYS; w++) begin : g_chk_way
            AST_DIRTY_VALID: assert property (@(posedge clk) disable iff (!rst_n) dirty_q[s][w] |-> valid_q[s][w]); // R12
        end
    end

endmodule

// File: tb/scrub_cache_test.sv
module scrub_cache_test;
    import scrub_cache_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         req_valid;
    logic         req_ready;
    logic [2:0]   req_op;
    logic [15:0]  req_addr;
    logic [31:0]  req_wdata;
    logic         resp_done;
    logic [31:0]  resp_rdata;
    logic         mem_valid;
    logic         mem_write;
    logic [15:0]  mem_addr;
    logic [127:0] mem_wdata;
    logic         mem_ready;
    logic [127:0] mem_rdata;

    logic [127:0] mem_model [0:255];
    int           rd_cnt = 0;
    int           wr_cnt = 0;
    logic [15:0]  last_wr_addr;
    logic [127:0] last_wr_data;

    int           checks = 0;
    int           errors = 0;
    logic [31:0]  got_data;
    int           got_lat;
    int           got_rd;
    int           got_wr;
    logic         busy_ready;
    logic         done_after;

    always #(CLK_PERIOD / 2) clk = ~clk;

    scrub_cache uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_op     (req_op),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .resp_done  (resp_done),
        .resp_rdata (resp_rdata),
        .mem_valid  (mem_valid),
        .mem_write  (mem_write),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_ready  (mem_ready),
        .mem_rdata  (mem_rdata)
    );

    function automatic logic [15:0] mk(int t, int s, int w);
        return {t[7:0], s[3:0], w[1:0], 2'b00};
    endfunction

    function automatic logic [31:0] pat(int li, int w);
        return 32'hA000_0000 | 32'(li << 4) | 32'(w);
    endfunction

    function automatic logic [127:0] pline(int li);
        return {pat(li, 3), pat(li, 2), pat(li, 1), pat(li, 0)};
    endfunction

    // memory responder: completes each transfer one cycle after it appears
    initial begin
        mem_ready = 1'b0;
        mem_rdata = '0;
        for (int i = 0; i < 256; i++) mem_model[i] = pline(i);
        forever begin
            @(negedge clk);
            if (mem_valid === 1'b1 && !mem_ready) begin
                if (mem_write) begin
                    mem_model[mem_addr[11:4]] = mem_wdata;
                    wr_cnt++;
                    last_wr_addr = mem_addr;
                    last_wr_data = mem_wdata;
                end else begin
                    mem_rdata = mem_model[mem_addr[11:4]];
                    rd_cnt++;
                end
                mem_ready = 1'b1;
            end else begin
                mem_ready = 1'b0;
            end
        end
    end

    task automatic chk(input string what, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic do_op(input scrub_op_e op, input int t, input int s, input int w, input logic [31:0] wv);
        int rd0, wr0, n;
        rd0 = rd_cnt;
        wr0 = wr_cnt;
        @(negedge clk);
        req_valid = 1'b1;
        req_op    = op;
        req_addr  = mk(t, s, w);
        req_wdata = wv;
        @(negedge clk);
        req_valid  = 1'b0;
        busy_ready = req_ready;
        n = 0;
        while (resp_done !== 1'b1 && n < 1000) begin
            @(negedge clk);
            n++;
        end
        got_lat  = n;
        got_data = resp_rdata;
        got_rd   = rd_cnt - rd0;
        got_wr   = wr_cnt - wr0;
        @(negedge clk);
        done_after = resp_done;
    endtask

    task automatic t_reset;
        chk("R11 req_ready after reset", 128'(req_ready), 128'(1));
        chk("R11 resp_done after reset", 128'(resp_done), 128'(0));
        chk("R11 mem_valid after reset", 128'(mem_valid), 128'(0));
    endtask

    task automatic t_load_and_handshake;
        do_op(OP_LOAD, 2, 1, 2, 0);
        chk("R1 load miss data", 128'(got_data), 128'(pat(33, 2)));
        chk("R1 load miss one fill", 128'(got_rd), 128'(1));
        chk("R10 ready low while busy", 128'(busy_ready), 128'(0));
        chk("R10 done lasts one cycle", 128'(done_after), 128'(0));
        do_op(OP_LOAD, 2, 1, 0, 0);
        chk("R1 load hit data", 128'(got_data), 128'(pat(33, 0)));
        chk("R1 load hit no memory", 128'(got_rd + got_wr), 128'(0));
        chk("R1 load hit latency", 128'(got_lat), 128'(1));
    endtask

    task automatic t_store_allocate;
        do_op(OP_STORE, 3, 2, 1, 32'h1234_5678);
        chk("R2 store miss fetches line", 128'(got_rd), 128'(1));
        chk("R2 store miss no write", 128'(got_wr), 128'(0));
        do_op(OP_LOAD, 3, 2, 1, 0);
        chk("R2 merged word", 128'(got_data), 128'(32'h1234_5678));
        do_op(OP_LOAD, 3, 2, 0, 0);
        chk("R2 neighbour word from memory", 128'(got_data), 128'(pat(50, 0)));
    endtask

    task automatic t_evict;
        do_op(OP_STORE, 1, 3, 0, 32'h0000_1111);
        for (int t = 2; t <= 4; t++) do_op(OP_LOAD, t, 3, 0, 0);
        do_op(OP_LOAD, 5, 3, 0, 0);
        chk("R3 dirty victim written", 128'(got_wr), 128'(1));
        chk("R3 write-back address", 128'(last_wr_addr), 128'(mk(1, 3, 0)));
        chk("R3 write-back data", last_wr_data, {pat(19, 3), pat(19, 2), pat(19, 1), 32'h0000_1111});
        do_op(OP_LOAD, 6, 3, 0, 0);
        chk("R3 clean victim silent", 128'(got_wr), 128'(0));
        do_op(OP_LOAD, 1, 3, 0, 0);
        chk("R3 refetch sees written data", 128'(got_data), 128'(32'h0000_1111));
    endtask

    task automatic t_drop;
        do_op(OP_STORE, 1, 4, 2, 32'hDEAD_0001);
        do_op(OP_DROP, 1, 4, 0, 0);
        chk("R4 drop no memory", 128'(got_rd + got_wr), 128'(0));
        do_op(OP_LOAD, 1, 4, 2, 0);
        chk("R4 dropped line refetched", 128'(got_rd), 128'(1));
        chk("R4 R12 dirty data discarded", 128'(got_data), 128'(pat(20, 2)));
        chk("R4 no write-back of dropped line", 128'(got_wr), 128'(0));
    endtask

    task automatic t_forget;
        int wr_sum;
        do_op(OP_STORE, 1, 5, 0, 32'hBEEF_0002);
        do_op(OP_FORGET, 1, 5, 0, 0);
        do_op(OP_LOAD, 1, 5, 0, 0);
        chk("R5 data kept after forget", 128'(got_data), 128'(32'hBEEF_0002));
        chk("R5 still resident", 128'(got_rd), 128'(0));
        wr_sum = 0;
        for (int t = 2; t <= 5; t++) begin
            do_op(OP_LOAD, t, 5, 0, 0);
            wr_sum += got_wr;
        end
        chk("R5 eviction writes nothing", 128'(wr_sum), 128'(0));
        do_op(OP_LOAD, 1, 5, 0, 0);
        chk("R5 memory unchanged", 128'(got_data), 128'(pat(21, 0)));
    endtask

    task automatic t_retire;
        for (int t = 1; t <= 4; t++) do_op(OP_LOAD, t, 6, 0, 0);
        do_op(OP_STORE, 2, 6, 1, 32'h2222_0003);
        do_op(OP_RETIRE, 2, 6, 0, 0);
        chk("R6 retire no memory", 128'(got_rd + got_wr), 128'(0));
        do_op(OP_LOAD, 5, 6, 0, 0);
        chk("R6 retired line evicted silently", 128'(got_wr), 128'(0));
        do_op(OP_LOAD, 1, 6, 0, 0);
        chk("R6 older line survives", 128'(got_rd), 128'(0));
        do_op(OP_LOAD, 2, 6, 1, 0);
        chk("R6 retired line gone", 128'(got_rd), 128'(1));
        chk("R6 retired data not kept", 128'(got_data), 128'(pat(38, 1)));
    endtask

    task automatic t_zfill;
        do_op(OP_ZFILL, 1, 7, 0, 0);
        chk("R7 zero miss no memory", 128'(got_rd + got_wr), 128'(0));
        do_op(OP_LOAD, 1, 7, 3, 0);
        chk("R7 zero line reads zero", 128'(got_data), 128'(0));
        chk("R7 zero line resident", 128'(got_lat), 128'(1));
        do_op(OP_LOAD, 2, 7, 1, 0);
        do_op(OP_ZFILL, 2, 7, 0, 0);
        chk("R7 zero hit no memory", 128'(got_rd), 128'(0));
        do_op(OP_LOAD, 2, 7, 1, 0);
        chk("R7 zero hit clears data", 128'(got_data), 128'(0));
        for (int t = 1; t <= 4; t++) do_op(OP_STORE, t, 8, 0, 32'h8000_0000 | 32'(t));
        do_op(OP_ZFILL, 5, 8, 0, 0);
        chk("R7 zero miss no fill", 128'(got_rd), 128'(0));
        chk("R7 dirty victim written first", 128'(got_wr), 128'(1));
        chk("R7 victim address", 128'(last_wr_addr), 128'(mk(1, 8, 0)));
        chk("R7 victim data", 128'(last_wr_data[31:0]), 128'(32'h8000_0001));
        for (int t = 6; t <= 9; t++) do_op(OP_LOAD, t, 8, 0, 0);
        chk("R7 R9 zero line dirty on eviction", 128'(last_wr_addr), 128'(mk(5, 8, 0)));
        chk("R7 zero line written as zero", last_wr_data, 128'(0));
    endtask

    task automatic t_scrub_miss;
        for (int t = 1; t <= 4; t++) do_op(OP_LOAD, t, 10, 0, 0);
        do_op(OP_RETIRE, 7, 10, 0, 0);
        chk("R8 retire miss one cycle", 128'(got_lat), 128'(1));
        do_op(OP_DROP, 8, 10, 0, 0);
        chk("R8 drop miss one cycle", 128'(got_lat), 128'(1));
        do_op(OP_FORGET, 9, 10, 0, 0);
        chk("R8 forget miss one cycle", 128'(got_lat), 128'(1));
        chk("R8 forget miss no memory", 128'(got_rd + got_wr), 128'(0));
        do_op(OP_LOAD, 5, 10, 0, 0);
        do_op(OP_LOAD, 2, 10, 0, 0);
        chk("R8 order unchanged, way two kept", 128'(got_rd), 128'(0));
        do_op(OP_LOAD, 1, 10, 0, 0);
        chk("R8 order unchanged, oldest evicted", 128'(got_rd), 128'(1));
    endtask

    task automatic t_lru;
        for (int t = 1; t <= 4; t++) do_op(OP_LOAD, t, 11, 0, 0);
        do_op(OP_LOAD, 1, 11, 0, 0);
        do_op(OP_LOAD, 5, 11, 0, 0);
        do_op(OP_LOAD, 1, 11, 0, 0);
        chk("R9 promoted line kept", 128'(got_rd), 128'(0));
        do_op(OP_LOAD, 2, 11, 0, 0);
        chk("R9 least recent line evicted", 128'(got_rd), 128'(1));
        chk("R9 refetched data", 128'(got_data), 128'(pat(43, 0)));
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n     = 1'b0;
        req_valid = 1'b0;
        req_op    = '0;
        req_addr  = '0;
        req_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load_and_handshake();
        t_store_allocate();
        t_evict();
        t_drop();
        t_forget();
        t_retire();
        t_zfill();
        t_scrub_miss();
        t_lru();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule